// File: doc/BRIEF.md
# Dual Compare-Match Event Timer

This block provides two independent event channels. Each channel has an up-counter, a compare (match) value and a control word. The control word holds three enable bits and a per-channel clock divider. Once a channel is enabled, its counter advances once every D+1 input clocks. On the clock edge where the counter becomes equal to the match value, the channel's bit in a shared pending-status register sets. An interrupt line for that channel is then driven as long as the bit stays set and the channel stays enabled.

Software uses a channel as a one-shot event source. It zeroes the counter, loads the match value with the desired delay, and sets the enable bits. When the interrupt arrives, it acknowledges the pending bit by writing a one to it and clears the enable bits. If the channel is left running, the counter keeps going, wraps around, and fires again at the next equality.

All registers are reached through a flat 32-bit register port: one write strobe, a byte address, write data, and combinational read data.

Each channel contains a small state machine with two states:
- **Stop**: the divider is held at phase zero and the counter is frozen.
- **Run**: the divider and the counter advance.

The transition ARM goes from Stop to Run when all three enable bits of the control word are set. The transition HALT goes from Run back to Stop as soon as any of those bits is cleared. Counting halts in the same cycle in which the enable bits drop.

Top module: `dual_match_timer`

## Requirements
- R1: After reset, every register reads zero and both interrupt outputs are low.
- R2: The register map places channel i's control word at byte 0x00+4i, its match value at 0x18+4i and its counter at 0x48+4i. The pending-status register is at 0x60, with bit i belonging to channel i. Written values read back, and the counter reads back only its CNT_W low bits, zero-extended. Any other address reads zero.
- R3: A channel counts only while its control bits [2:0] equal 3'b111. With any of them clear, the counter holds its value.
- R4: Control bits [31:16] hold the divider D. Counting starts from a counter of zero with the enabling write taking effect at clock edge E0. The counter first advances at edge E0+D+2 and then once every D+1 edges, so K edges after E0 it reads floor((K-1)/(D+1)).
- R5: Status bit i sets on the edge where channel i's counter steps to its match value M. Starting from zero, that edge is E0+M(D+1)+1.
- R6: Interrupt output i is high exactly while status bit i is set and channel i is enabled. Clearing the enable bits drops the output but keeps the status bit.
- R7: Writing to the status register clears each bit written as one. Bits written as zero are unchanged, and writing 0xFFFF clears every pending bit.
- R8: If a match event and a clearing write to the same status bit occur on the same edge, the bit ends up set.
- R9: After a match, the counter keeps counting, wraps from 2^CNT_W-1 to zero, and raises a new event only when it next equals the match value.
- R10: A direct write to a counter overrides any increment on that edge and never sets a status bit by itself, even when the written value equals the match value.
- R11: The channels are independent: one channel's activity changes neither the other's counter nor its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 8 | Byte address of the register being accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | NUM_CH | Per-channel interrupt outputs |

## Verification
The bench builds the block with NUM_CH=2, PSC_W=16 and CNT_W=8. The narrow counter puts the wrap from 255 back to zero, and the re-fire that follows it, a few hundred cycles into the run. That makes R9 observable without waiting 2^32 ticks. Divider values of 0 and 2 exercise both the every-clock case and the case where the count lags the enable by several clocks, and the expected edge counts are derived from the R4 and R5 formulas. One match event is placed exactly on the edge of a clearing write to check R8.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    // Byte offsets within the register window
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_MATCH  = 8'h18;
    localparam logic [7:0] OFS_COUNT  = 8'h48;
    localparam logic [7:0] OFS_STATUS = 8'h60;
    localparam int         CH_STRIDE  = 4;

    // Control word layout
    localparam int         EN_LSB     = 0;
    localparam int         EN_W       = 3;
    localparam logic [2:0] EN_ALL     = 3'b111;
    localparam int         DIV_LSB    = 16;

    typedef enum logic [0:0] {
        CH_STOP = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

endpackage

// File: rtl/dmt_prescaler.sv
module dmt_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    logic [PSC_W-1:0] phase_q;

    // Reaching or passing div ends the period (div may shrink mid-period)
    assign tick = run && (phase_q >= div);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div == '0)); // R4

    AST_IDLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (phase_q == '0)); // R3

endmodule

// File: rtl/dmt_channel.sv
module dmt_channel
    import dmt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             match_we,
    input  logic             cnt_we,
    input  logic [31:0]      wdata,
    output logic [31:0]      ctrl_q,
    output logic [CNT_W-1:0] match_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             enabled,
    output logic             hit
);
    ch_state_e        state_q, state_d;
    logic             run;
    logic             tick;
    logic [CNT_W-1:0] cnt_inc;
    logic [PSC_W-1:0] div;

    assign enabled = (ctrl_q[EN_LSB +: EN_W] == EN_ALL);
    assign div     = ctrl_q[DIV_LSB +: PSC_W];
    assign cnt_inc = cnt_q + 1'b1;

    // Next-state logic: ARM and HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOP: if (enabled)  state_d = CH_RUN;
            CH_RUN:  if (!enabled) state_d = CH_STOP;
            default: state_d = CH_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_STOP;
        else        state_q <= state_d;
    end

    // Outputs of the state machine
    always_comb begin
        run = 1'b0;
        unique case (state_q)
            CH_STOP: run = 1'b0;
            CH_RUN:  run = enabled;
            default: run = 1'b0;
        endcase
    end

    dmt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div),
        .tick  (tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            match_q <= '0;
        end else begin
            if (ctrl_we)  ctrl_q  <= wdata;
            if (match_we) match_q <= wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_we) cnt_q <= wdata[CNT_W-1:0];
        else if (tick)   cnt_q <= cnt_inc;
    end

    // Event when the stepping counter lands on the match value
    assign hit = tick && !cnt_we && (cnt_inc == match_q);

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_we) |=> $stable(cnt_q)); // R3

    AST_HIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cnt_q == $past(match_q))); // R5

    AST_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && state_q == CH_STOP) |=> (state_q == CH_RUN)); // R3

    AST_WRITE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |-> !hit); // R10

endmodule

// File: rtl/dmt_status.sv
module dmt_status #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] clr_mask,
    output logic [NUM_CH-1:0] status_q
);
    logic [NUM_CH-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_eff) | hit;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> status_q[g]); // R8

        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_mask[g] && !hit[g]) |=> !status_q[g]); // R7

        AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
            (!status_q[g] && !hit[g]) |=> !status_q[g]); // R10
    end

endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
    import dmt_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32,
    parameter int PSC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_CH-1:0] irq
);
    logic [31:0]      ctrl_arr  [NUM_CH];
    logic [CNT_W-1:0] match_arr [NUM_CH];
    logic [CNT_W-1:0] cnt_arr   [NUM_CH];
    logic [7:0]       a_ctrl    [NUM_CH];
    logic [7:0]       a_match   [NUM_CH];
    logic [7:0]       a_cnt     [NUM_CH];
    logic [NUM_CH-1:0] en_vec;
    logic [NUM_CH-1:0] hit_vec;
    logic [NUM_CH-1:0] status_q;
    logic              status_we;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [7:0] STEP = 8'(CH_STRIDE * g);

        assign a_ctrl[g]  = OFS_CTRL  + STEP;
        assign a_match[g] = OFS_MATCH + STEP;
        assign a_cnt[g]   = OFS_COUNT + STEP;

        dmt_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_we  (reg_we && reg_addr == a_ctrl[g]),
            .match_we (reg_we && reg_addr == a_match[g]),
            .cnt_we   (reg_we && reg_addr == a_cnt[g]),
            .wdata    (reg_wdata),
            .ctrl_q   (ctrl_arr[g]),
            .match_q  (match_arr[g]),
            .cnt_q    (cnt_arr[g]),
            .enabled  (en_vec[g]),
            .hit      (hit_vec[g])
        );

        assign irq[g] = status_q[g] & en_vec[g];

        AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[g] && !(reg_we && reg_addr == OFS_STATUS && reg_wdata[g])) |=> status_q[g]); // R6
    end

    assign status_we = reg_we && (reg_addr == OFS_STATUS);

    dmt_status #(.NUM_CH(NUM_CH)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit_vec),
        .clr_we   (status_we),
        .clr_mask (reg_wdata[NUM_CH-1:0]),
        .status_q (status_q)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_STATUS) reg_rdata = 32'(status_q);
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr == a_ctrl[i])  reg_rdata = ctrl_arr[i];
            if (reg_addr == a_match[i]) reg_rdata = 32'(match_arr[i]);
            if (reg_addr == a_cnt[i])   reg_rdata = 32'(cnt_arr[i]);
        end
    end

endmodule

// File: tb/dual_match_timer_test.sv
`timescale 1ns/100ps
module dual_match_timer_test;
    localparam int NCH = 2;
    localparam int CW  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NCH-1:0] irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dual_match_timer #(.NUM_CH(NCH), .CNT_W(CW), .PSC_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #0.5;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
    endtask

    task automatic edges(input int k);
        repeat (k) @(posedge clk);
        #0.5;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        foreach (uut.a_ctrl[i]) begin end
        rd(8'h00, d); chk("R1 ctrl0", d, 0);
        rd(8'h1c, d); chk("R1 match1", d, 0);
        rd(8'h48, d); chk("R1 count0", d, 0);
        rd(8'h60, d); chk("R1 status", d, 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(8'h00, 32'h0003_0000);
        wr(8'h1c, 32'h0000_00a5);
        wr(8'h48, 32'h0000_1234);
        rd(8'h00, d); chk("R2 ctrl0 readback", d, 32'h0003_0000);
        rd(8'h1c, d); chk("R2 match1 readback", d, 32'h0000_00a5);
        rd(8'h48, d); chk("R2 count0 truncated", d, 32'h0000_0034);
        rd(8'h10, d); chk("R2 unmapped", d, 0);
        wr(8'h00, 32'h0000_0003);
        edges(10);
        rd(8'h48, d); chk("R3 partial enable holds", d, 32'h34);
        wr(8'h00, 32'h0);
        wr(8'h1c, 32'h0);
    endtask

    task automatic t_oneshot();
        logic [31:0] d;
        wr(8'h48, 0);
        wr(8'h18, 4);
        wr(8'h00, 32'h0002_0007);
        edges(3);  rd(8'h48, d); chk("R4 K=3", d, 0);
        edges(1);  rd(8'h48, d); chk("R4 K=4", d, 1);
        edges(8);  rd(8'h48, d); chk("R4 K=12", d, 3);
        rd(8'h60, d); chk("R5 not yet", d, 0);
        edges(1);  rd(8'h60, d); chk("R5 event edge", d, 1);
        rd(8'h48, d); chk("R5 count at match", d, 4);
        chk("R6 irq raised", 32'(irq), 1);
        wr(8'h00, 32'h0002_0000);
        chk("R6 irq drops", 32'(irq), 0);
        rd(8'h60, d); chk("R6 status kept", d, 1);
        wr(8'h60, 1);
        rd(8'h60, d); chk("R7 w1c", d, 0);
        edges(10);
        rd(8'h48, d); chk("R3 disabled holds", d, 4);
    endtask

    task automatic t_wrap();
        logic [31:0] c, s;
        bit seen_zero;
        wr(8'h4c, 0);
        wr(8'h1c, 3);
        wr(8'h04, 32'h7);
        edges(3); rd(8'h4c, c); chk("R4 D=0 K=3", c, 2);
        rd(8'h60, s); chk("R5 D=0 not yet", s, 0);
        edges(1); rd(8'h60, s); chk("R5 D=0 event", s, 2);
        wr(8'h60, 2);
        rd(8'h60, s); chk("R7 clear ch1", s, 0);
        seen_zero = 0;
        for (int i = 0; i < 600; i++) begin
            edges(1);
            rd(8'h4c, c);
            rd(8'h60, s);
            if (c == 0) seen_zero = 1;
            if (s[1]) break;
        end
        chk("R9 wrapped before refire", 32'(seen_zero), 1);
        chk("R9 refire at match", c, 3);
        chk("R9 refire status", s, 2);
        rd(8'h48, c); chk("R11 ch0 count untouched", c, 4);
        wr(8'h04, 0);
        wr(8'h60, 2);
    endtask

    task automatic t_setwins();
        logic [31:0] s, c;
        wr(8'h4c, 0);
        wr(8'h1c, 5);
        wr(8'h04, 32'h7);
        edges(5);
        wr(8'h60, 2);
        rd(8'h60, s); chk("R8 set beats clear", s, 2);
        wr(8'h60, 2);
        rd(8'h60, s); chk("R7 clear after", s, 0);
        wr(8'h4c, 5);
        rd(8'h60, s); chk("R10 write equal match", s, 0);
        edges(3);
        rd(8'h60, s); chk("R10 no event later", s, 0);
        rd(8'h4c, c); chk("R10 counting resumes", c, 8);
        wr(8'h04, 0);
    endtask

    task automatic t_both();
        logic [31:0] s;
        wr(8'h48, 0); wr(8'h18, 1); wr(8'h00, 32'h7);
        wr(8'h4c, 0); wr(8'h1c, 1); wr(8'h04, 32'h7);
        edges(4);
        rd(8'h60, s); chk("R11 both pending", s, 3);
        chk("R6 both irq", 32'(irq), 3);
        wr(8'h60, 0);
        rd(8'h60, s); chk("R7 zero write keeps", s, 3);
        wr(8'h60, 32'hffff);
        rd(8'h60, s); chk("R7 clear all", s, 0);
        chk("R6 irq after clear", 32'(irq), 0);
        wr(8'h00, 0); wr(8'h04, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_regmap();
        t_oneshot();
        t_wrap();
        t_setwins();
        t_both();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule